// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns frames stored as 32-bit words in a transmit queue into a byte stream ready for a MAC transmit path. Each frame in the queue opens with a two-byte payload length that steers the block and is never sent. After it come the destination and source addresses, the length/type field and the payload. The block adds zero bytes to a short payload so that it reaches the Ethernet minimum. It either computes and appends the CRC-32 frame check sequence itself or forwards check bytes that software has stored in the queue.

The queue is read through a show-ahead interface: the read data is valid whenever the empty flag is low, and a read strobe pops one word. The output is a byte channel with valid/ready flow control and a last marker on the final byte. Three control inputs gate frame start, turn on padding and select automatic check-sequence insertion. The padding and insertion settings are captured when a frame starts. A queue that runs dry part way through a frame aborts it and raises a one-cycle underrun pulse.

Top module: `eth_tx_assembler`

## Requirements
- R1: Bytes are taken from each queue word starting with bits 7:0, then 15:8, 23:16 and 31:24. The first two bytes of a frame form the payload length, low byte first, and are not sent.
- R2: The 14 header bytes (6 destination, 6 source, 2 length/type) and then exactly the number of payload bytes given by the length field appear on the output in queue order.
- R3: With padding on and a payload length below 46, zero bytes follow the payload until 46 payload-plus-pad bytes have been sent. A payload of 46 bytes or more gets no pad.
- R4: With padding off, no pad byte is sent, whatever the payload length.
- R5: With insertion on, four check bytes follow the payload and pad. They hold the IEEE 802.3 CRC-32 (reflected polynomial 0xEDB88320, preset all ones, result inverted) over the header, payload and pad, least significant byte first.
- R6: With insertion off, the four queue bytes after the payload are sent unchanged after any pad.
- R7: The last marker is high on the final check byte of a frame and on no other byte. An aborted frame never shows it.
- R8: While valid is high and ready is low, the output data and last marker hold their values and valid stays high.
- R9: While the enable input is low, no frame starts and no queue word is read.
- R10: Lanes of a frame's final word beyond its last byte are discarded, and the next frame begins at lane 0 of the next word.
- R11: If the queue is empty when a frame needs its next queue byte, the block pulses the underrun output for one cycle, drops the frame and goes idle, ready for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_en | input | 1 | Allows a new frame to start |
| cfg_pad_en | input | 1 | Pad short payloads with zeros |
| cfg_fcs_ins | input | 1 | Generate and append the check sequence |
| fifo_empty | input | 1 | Queue has no word |
| fifo_rd_data | input | DATA_W | Head word of the queue (show-ahead) |
| fifo_rd_en | output | 1 | Pops the head word |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| err_underrun | output | 1 | One-cycle pulse when a frame is aborted |

## Verification
Output backpressure and the queue word boundary can fall in the same cycle. The block may be fetching a new word or crossing from payload into pad or check bytes while the output register is stalled. The bench provokes this with a repeating ready pattern that drops ready several times within each 16-cycle span, using odd payload lengths so that the stalls land on varied lanes and section boundaries. It judges the outcome by comparing the full accepted byte stream and its last markers against a model built from the requirements, and by checking that every stalled byte was held unchanged.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    localparam int LEN_W     = 16;
    localparam int HDR_BYTES = 14;
    localparam int FCS_BYTES = 4;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEN,
        S_HDR,
        S_PAY,
        S_PAD,
        S_FCS_PASS,
        S_FCS_GEN
    } tx_state_e;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_tx_word_buf.sv
module eth_tx_word_buf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              fifo_rd_en,
    input  logic              want,
    input  logic              take,
    input  logic              flush,
    output logic              byte_vld,
    output logic [7:0]        byte_data
);

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LANE_MAX = LANE_W'(LANES - 1);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [LANE_W-1:0] lane;
        logic              vld;
    } wb_t;

    wb_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        fifo_rd_en = want && !st_q.vld && !fifo_empty && !flush;
        if (flush) begin
            st_d.vld = 1'b0;
        end else if (take) begin
            if (st_q.lane == LANE_MAX) begin
                st_d.vld  = 1'b0;
                st_d.lane = '0;
            end else begin
                st_d.lane = st_q.lane + 1'b1;
            end
        end else if (fifo_rd_en) begin
            st_d.word = fifo_rd_data;
            st_d.lane = '0;
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_vld  = st_q.vld;
    assign byte_data = st_q.word[st_q.lane*8 +: 8];

    // R1: the controller only consumes a byte that the buffer holds
    a_r1_take_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> st_q.vld);

endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_state
);
    import eth_tx_pkg::*;

    typedef struct packed {
        logic [31:0] crc;
    } crc_t;

    crc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init) begin
            st_d.crc = CRC_PRESET;
        end else if (en) begin
            st_d.crc = crc32_step(st_q.crc, din);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.crc <= CRC_PRESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_state = st_q.crc;

endmodule

// File: rtl/eth_tx_out_reg.sv
module eth_tx_out_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       lin,
    output logic       can_push,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    input  logic       tx_ready
);

    typedef struct packed {
        logic       vld;
        logic [7:0] data;
        logic       last;
    } oreg_t;

    oreg_t st_d, st_q;

    assign can_push = !st_q.vld || tx_ready;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.vld  = 1'b1;
            st_d.data = din;
            st_d.last = lin;
        end else if (tx_ready) begin
            st_d.vld  = 1'b0;
            st_d.last = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.vld;
    assign tx_data  = st_q.data;
    assign tx_last  = st_q.last;

    // R8: a stalled byte is held
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R7: the last marker only travels with a valid byte
    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

endmodule

// File: rtl/eth_tx_assembler.sv
module eth_tx_assembler #(
    parameter int DATA_W      = 32,
    parameter int MIN_PAYLOAD = 46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_pad_en,
    input  logic              cfg_fcs_ins,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              fifo_rd_en,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              err_underrun
);
    import eth_tx_pkg::*;

    localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(MIN_PAYLOAD);
    localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_BYTES - 1);
    localparam logic [LEN_W-1:0] FCS_LAST = LEN_W'(FCS_BYTES - 1);

    typedef struct packed {
        tx_state_e        state;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic             pad_en;
        logic             fcs_ins;
        logic             err;
    } ctl_t;

    ctl_t st_d, st_q;

    logic        want, take, flush, byte_vld;
    logic [7:0]  byte_data;
    logic        push, plast, can_push;
    logic [7:0]  pbyte;
    logic        crc_init, crc_en;
    logic [31:0] crc_state, fcs_word;
    logic        starve;
    tx_state_e   fcs_state, tail_state;
    logic [LEN_W-1:0] tail_cnt;

    eth_tx_word_buf #(.DATA_W(DATA_W)) u_wbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_empty  (fifo_empty),
        .fifo_rd_data(fifo_rd_data),
        .fifo_rd_en  (fifo_rd_en),
        .want        (want),
        .take        (take),
        .flush       (flush),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data)
    );

    eth_tx_crc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (crc_init),
        .en       (crc_en),
        .din      (pbyte),
        .crc_state(crc_state)
    );

    eth_tx_out_reg u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .din     (pbyte),
        .lin     (plast),
        .can_push(can_push),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_last (tx_last),
        .tx_ready(tx_ready)
    );

    assign fcs_word = ~crc_state;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        push     = 1'b0;
        pbyte    = '0;
        plast    = 1'b0;
        take     = 1'b0;
        flush    = 1'b0;
        crc_init = 1'b0;
        crc_en   = 1'b0;

        want   = (st_q.state == S_LEN) || (st_q.state == S_HDR) ||
                 (st_q.state == S_PAY) || (st_q.state == S_FCS_PASS);
        starve = want && !byte_vld && fifo_empty;

        fcs_state = st_q.fcs_ins ? S_FCS_GEN : S_FCS_PASS;
        if (st_q.pad_en && (st_q.len < MIN_LEN)) begin
            tail_state = S_PAD;
            tail_cnt   = st_q.len;
        end else begin
            tail_state = fcs_state;
            tail_cnt   = '0;
        end

        case (st_q.state)
            S_IDLE: begin
                if (cfg_tx_en && !fifo_empty) begin
                    st_d.state   = S_LEN;
                    st_d.cnt     = '0;
                    st_d.pad_en  = cfg_pad_en;
                    st_d.fcs_ins = cfg_fcs_ins;
                    crc_init     = 1'b1;
                end
            end
            S_LEN: begin
                if (byte_vld) begin
                    take = 1'b1;
                    if (!st_q.cnt[0]) begin
                        st_d.len[7:0] = byte_data;
                        st_d.cnt      = LEN_W'(1);
                    end else begin
                        st_d.len[15:8] = byte_data;
                        st_d.cnt       = '0;
                        st_d.state     = S_HDR;
                    end
                end
            end
            S_HDR: begin
                if (byte_vld && can_push) begin
                    push   = 1'b1;
                    pbyte  = byte_data;
                    take   = 1'b1;
                    crc_en = 1'b1;
                    if (st_q.cnt == HDR_LAST) begin
                        if (st_q.len != '0) begin
                            st_d.state = S_PAY;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.state = tail_state;
                            st_d.cnt   = tail_cnt;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            S_PAY: begin
                if (byte_vld && can_push) begin
                    push   = 1'b1;
                    pbyte  = byte_data;
                    take   = 1'b1;
                    crc_en = 1'b1;
                    if (st_q.cnt == st_q.len - 1'b1) begin
                        st_d.state = tail_state;
                        st_d.cnt   = tail_cnt;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            S_PAD: begin
                if (can_push) begin
                    push   = 1'b1;
                    crc_en = 1'b1;
                    if (st_q.cnt == MIN_LEN - 1'b1) begin
                        st_d.state = fcs_state;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            S_FCS_PASS: begin
                if (byte_vld && can_push) begin
                    push  = 1'b1;
                    pbyte = byte_data;
                    take  = 1'b1;
                    plast = (st_q.cnt == FCS_LAST);
                    if (plast) begin
                        flush      = 1'b1;
                        st_d.state = S_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            S_FCS_GEN: begin
                if (can_push) begin
                    push  = 1'b1;
                    pbyte = fcs_word[{st_q.cnt[1:0], 3'b000} +: 8];
                    plast = (st_q.cnt == FCS_LAST);
                    if (plast) begin
                        flush      = 1'b1;
                        st_d.state = S_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d.state = S_IDLE;
        endcase

        if (starve) begin
            st_d.state = S_IDLE;
            st_d.err   = 1'b1;
            flush      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_underrun = st_q.err;

    // R9: nothing is pulled from the queue while idle and disabled
    a_r9_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_IDLE && !cfg_tx_en) |-> !fifo_rd_en);

    // R11: an underrun follows a cycle in which the queue was empty
    a_r11_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun |-> $past(fifo_empty));

    // R7: an aborted frame carries no last marker
    a_r7_abort_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun |-> !tx_last);

endmodule

// File: tb/tb_eth_tx_assembler.sv
module tb_eth_tx_assembler;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cfg_tx_en, cfg_pad_en, cfg_fcs_ins;
    logic        fifo_empty, fifo_rd_en;
    logic [31:0] fifo_rd_data;
    logic        tx_valid, tx_last, tx_ready, err_underrun;
    logic [7:0]  tx_data;

    eth_tx_assembler dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_pad_en(cfg_pad_en),
        .cfg_fcs_ins(cfg_fcs_ins), .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data),
        .fifo_rd_en(fifo_rd_en), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .err_underrun(err_underrun)
    );

    // queue model, show-ahead
    logic [31:0] fmem [0:1023];
    logic [15:0] wp = 0, rp = 0;
    assign fifo_empty   = (wp == rp);
    assign fifo_rd_data = fmem[rp[9:0]];
    always @(posedge clk) begin
        if (fifo_rd_en) begin
            #1 rp = rp + 1;
        end
    end

    // ready pattern
    logic       stall_mode = 1'b0;
    logic [3:0] rcnt = 0;
    always @(posedge clk) rcnt <= rcnt + 1'b1;
    assign tx_ready = stall_mode ? ((rcnt[1:0] != 2'b00) && (rcnt != 4'd7)) : 1'b1;

    // output capture
    logic [7:0] rx_b [0:2047];
    logic       rx_l [0:2047];
    int rx_n = 0, ur_n = 0, hold_err = 0;
    logic hold_pend = 1'b0, hold_l;
    logic [7:0] hold_d;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && !(tx_valid && tx_data == hold_d && tx_last == hold_l))
                hold_err++;
            hold_pend = tx_valid && !tx_ready;
            hold_d    = tx_data;
            hold_l    = tx_last;
            if (tx_valid && tx_ready) begin
                rx_b[rx_n] = tx_data;
                rx_l[rx_n] = tx_last;
                rx_n++;
            end
            if (err_underrun) ur_n++;
        end
    end

    logic [7:0] ex_b [0:2047];
    logic       ex_l [0:2047];
    int ex_n = 0;
    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c0, input logic [7:0] b);
        logic [31:0] c;
        c = c0;
        for (int k = 0; k < 8; k++) begin
            if (c[k % 1 + 0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
            else                     c = c >> 1;
        end
        return c;
    endfunction

    task automatic clear_capture();
        rx_n = 0; ex_n = 0; ur_n = 0; hold_err = 0;
    endtask

    // Builds one frame in the queue and, unless truncated, its expected output.
    task automatic add_frame(input int len, input bit padon, input bit fcson, input int seed, input int trunc_words);
        logic [7:0] qb[$];
        logic [7:0] fr[$];
        logic [31:0] c, w;
        int nw, idx;
        qb.push_back(len[7:0]);
        qb.push_back(len[15:8]);
        for (int i = 0; i < 6; i++) begin qb.push_back(8'h10 + 8'(i)); fr.push_back(8'h10 + 8'(i)); end
        for (int i = 0; i < 6; i++) begin qb.push_back(8'h20 + 8'(i)); fr.push_back(8'h20 + 8'(i)); end
        qb.push_back(8'h88); fr.push_back(8'h88);
        qb.push_back(8'hB5); fr.push_back(8'hB5);
        for (int i = 0; i < len; i++) begin
            qb.push_back(8'(seed + i * 7 + 1)); fr.push_back(8'(seed + i * 7 + 1));
        end
        if (padon) for (int i = len; i < 46; i++) fr.push_back(8'h00);
        if (fcson) begin
            c = 32'hFFFFFFFF;
            foreach (fr[i]) c = crc_byte(c, fr[i]);
            c = ~c;
            for (int i = 0; i < 4; i++) fr.push_back(c[8*i +: 8]);
        end else begin
            qb.push_back(8'hDE); qb.push_back(8'hAD); qb.push_back(8'hBE); qb.push_back(8'hEF);
            fr.push_back(8'hDE); fr.push_back(8'hAD); fr.push_back(8'hBE); fr.push_back(8'hEF);
        end
        nw  = (qb.size() + 3) / 4;
        if (trunc_words > 0) nw = trunc_words;
        idx = 0;
        for (int wdx = 0; wdx < nw; wdx++) begin
            for (int l = 0; l < 4; l++) begin
                w[8*l +: 8] = (idx < qb.size()) ? qb[idx] : 8'hA5;
                idx++;
            end
            fmem[wp[9:0]] = w;
            wp = wp + 1;
        end
        if (trunc_words == 0) begin
            foreach (fr[i]) begin
                ex_b[ex_n] = fr[i];
                ex_l[ex_n] = (i == fr.size() - 1);
                ex_n++;
            end
        end
    endtask

    task automatic wait_bytes(input int n);
        int t = 0;
        while (rx_n < n && t < 5000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
    endtask

    task automatic compare_stream(input string tag);
        int bad = -1, badl = -1;
        chk(rx_n == ex_n, {tag, " byte count"}, rx_n, ex_n);
        for (int i = 0; i < ex_n && i < rx_n; i++) begin
            if (bad < 0 && rx_b[i] !== ex_b[i]) bad = i;
            if (badl < 0 && rx_l[i] !== ex_l[i]) badl = i;
        end
        if (bad >= 0) chk(1'b0, {tag, " data"}, rx_b[bad], ex_b[bad]);
        else          chk(1'b1, {tag, " data"}, 0, 0);
        if (badl >= 0) chk(1'b0, {tag, " R7 last flag"}, rx_l[badl], ex_l[badl]);
        else           chk(1'b1, {tag, " R7 last flag"}, 0, 0);
    endtask

    task automatic run_one(input int len, input bit padon, input bit fcson, input bit stall, input string tag);
        @(negedge clk);
        clear_capture();
        stall_mode  = stall;
        cfg_pad_en  = padon;
        cfg_fcs_ins = fcson;
        add_frame(len, padon, fcson, len * 3, 0);
        cfg_tx_en = 1'b1;
        wait_bytes(ex_n);
        cfg_tx_en = 1'b0;
        compare_stream(tag);
        chk(wp == rp, {tag, " R10 queue drained"}, rp, wp);
        if (stall) chk(hold_err == 0, {tag, " R8 hold under stall"}, hold_err, 0);
    endtask

    task automatic t_reset();
        chk(tx_valid == 1'b0, "R7 reset valid low", tx_valid, 0);
        chk(fifo_rd_en == 1'b0, "R9 reset no read", fifo_rd_en, 0);
        chk(err_underrun == 1'b0, "R11 reset no underrun", err_underrun, 0);
    endtask

    task automatic t_crc_vector();
        logic [31:0] c = 32'hFFFFFFFF;
        string s = "123456789";
        for (int i = 0; i < 9; i++) c = crc_byte(c, s[i]);
        chk(~c == 32'hCBF43926, "R5 bench crc reference", ~c, 32'hCBF43926);
    endtask

    task automatic t_disabled();
        logic [15:0] rp0;
        @(negedge clk);
        clear_capture();
        stall_mode = 1'b0; cfg_pad_en = 1'b1; cfg_fcs_ins = 1'b1; cfg_tx_en = 1'b0;
        rp0 = rp;
        add_frame(12, 1'b1, 1'b1, 5, 0);
        repeat (40) @(negedge clk);
        chk(rp == rp0, "R9 no read while disabled", rp, rp0);
        chk(rx_n == 0, "R9 no output while disabled", rx_n, 0);
        cfg_tx_en = 1'b1;
        wait_bytes(ex_n);
        cfg_tx_en = 1'b0;
        compare_stream("R9 frame after enable");
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        clear_capture();
        stall_mode = 1'b1; cfg_pad_en = 1'b0; cfg_fcs_ins = 1'b1;
        add_frame(7, 1'b0, 1'b1, 40, 0);
        add_frame(9, 1'b0, 1'b1, 90, 0);
        cfg_tx_en = 1'b1;
        wait_bytes(ex_n);
        cfg_tx_en = 1'b0;
        compare_stream("R10 two odd frames");
        chk(wp == rp, "R10 queue drained", rp, wp);
        chk(hold_err == 0, "R8 hold under stall", hold_err, 0);
    endtask

    task automatic t_underrun();
        int lasts = 0;
        @(negedge clk);
        clear_capture();
        stall_mode = 1'b0; cfg_pad_en = 1'b1; cfg_fcs_ins = 1'b1;
        add_frame(20, 1'b1, 1'b1, 11, 3);
        cfg_tx_en = 1'b1;
        repeat (60) @(negedge clk);
        chk(ur_n == 1, "R11 underrun pulse count", ur_n, 1);
        chk(rx_n == 10, "R11 bytes before abort", rx_n, 10);
        for (int i = 0; i < rx_n; i++) if (rx_l[i]) lasts++;
        chk(lasts == 0, "R7 R11 no last on aborted frame", lasts, 0);
        clear_capture();
        add_frame(4, 1'b1, 1'b1, 17, 0);
        wait_bytes(ex_n);
        cfg_tx_en = 1'b0;
        compare_stream("R11 recovery frame");
        chk(ur_n == 0, "R11 no further underrun", ur_n, 0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_tx_en = 1'b0; cfg_pad_en = 1'b0; cfg_fcs_ins = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_crc_vector();
        run_one(50, 1'b1, 1'b1, 1'b0, "R1 R2 R5 long frame");
        run_one(10, 1'b1, 1'b1, 1'b1, "R3 R5 short padded");
        run_one(46, 1'b1, 1'b1, 1'b1, "R3 exact minimum no pad");
        run_one(5, 1'b0, 1'b0, 1'b0, "R4 R6 no pad passthrough");
        run_one(0, 1'b1, 1'b0, 1'b1, "R3 R6 empty payload padded");
        run_one(13, 1'b0, 1'b1, 1'b1, "R4 R5 unpadded generated");
        t_disabled();
        t_back_to_back();
        t_underrun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule